// File: doc/BRIEF.md
# Receive FIFO Pause Watermark Controller

This block sits beside a receive FIFO and decides when the link partner should be told to stop sending. From the FIFO capacity, a parameter, and the configured maximum transfer unit, it works out an upper and a lower fill threshold. While the FIFO fills it compares the byte occupancy against the upper threshold. It emits a single-cycle pause request when that threshold is reached. It emits a single-cycle resume request once the level has drained to the lower threshold. Between the two thresholds the state does not change, which gives hysteresis.

Software-visible configuration is loaded only on a strobe. At that moment the thresholds, a pause timer value and the held threshold outputs are recomputed and registered. The pause quanta value depends only on the FIFO capacity and is constant. Building and transmitting the PAUSE frame is left to a neighbouring block.

Top module: `pause_wm_ctrl`

## Requirements
- R1: On a configuration strobe the upper threshold becomes the larger of (capacity − 3·frame) and ⌊capacity·38/100⌋, limited to at most capacity − 8192 bytes. It is held on `hwm_units` as ⌊bytes/8⌋.
- R2: On a strobe the lower threshold becomes the smaller of 3·frame and capacity/4 bytes. It is held on `lwm_units` as ⌊bytes/8⌋.
- R3: The frame size is `cfg_mtu` + 14. When that sum is greater than 1536, 4 more bytes are added; a sum of exactly 1536 gets nothing added.
- R4: When `cfg_fc_en` is 0 at the strobe, `hwm_units` is 0 and no pause request is raised at any occupancy.
- R5: On a strobe `pause_timer` becomes ⌊(upper − lower bytes)·4 / d⌋. Here d is 8 when `cfg_div_sel` is 0 and 64 when it is 1. This value does not depend on `cfg_fc_en`.
- R6: `pause_quanta` always equals capacity·32/512.
- R7: `pause_req` pulses for one cycle, in the cycle after the clock edge at which ⌊`fill_bytes`/8⌋ ≥ `hwm_units` (nonzero) is first seen while not paused. It is not raised again before a resume.
- R8: While paused, `resume_req` pulses for one cycle after the edge at which ⌊`fill_bytes`/8⌋ ≤ `lwm_units` is seen. Occupancy between the two thresholds produces no request.
- R9: Without a strobe, `hwm_units`, `lwm_units` and `pause_timer` keep their values whatever the configuration inputs do.
- R10: After reset, `pause_req` and `resume_req` are 0, and `hwm_units`, `lwm_units` and `pause_timer` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_strobe | input | 1 | Load configuration and recompute thresholds |
| cfg_mtu | input | MTU_W | Maximum transfer unit in bytes |
| cfg_fc_en | input | 1 | Enable pause generation (transmit flow control) |
| cfg_div_sel | input | 1 | Pause timer divisor select: 0 → 8, 1 → 64 |
| fill_bytes | input | OCC_W | Current FIFO occupancy in bytes |
| pause_req | output | 1 | One-cycle request to send a PAUSE frame |
| resume_req | output | 1 | One-cycle request to resume the partner |
| pause_quanta | output | 16 | Pause quanta to advertise |
| pause_timer | output | 16 | Pause refresh timer value |
| hwm_units | output | OCC_W-3 | Upper threshold in 8-byte units (0 = off) |
| lwm_units | output | OCC_W-3 | Lower threshold in 8-byte units |

## Verification
The assertions assume that `fill_bytes` never exceeds the FIFO capacity. They also assume that `cfg_mtu` keeps the frame size no larger than the capacity, so the lower threshold always sits below the upper one. The stimulus uses only transfer units from 1500 to 9000 bytes with a 32768-byte FIFO, and occupancy values below 32768. It changes the configuration inputs without a strobe only to show that the held thresholds do not move. Requests are checked one cycle after each occupancy change. Occupancy values are chosen one 8-byte unit either side of each threshold.

// File: rtl/pause_wm_ctrl.sv
module pause_wm_ctrl #(
  parameter int FIFO_BYTES = 32768,
  parameter int MTU_W      = 14,
  parameter int OCC_W      = $clog2(FIFO_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_strobe,
  input  logic [MTU_W-1:0] cfg_mtu,
  input  logic             cfg_fc_en,
  input  logic             cfg_div_sel,
  input  logic [OCC_W-1:0] fill_bytes,
  output logic             pause_req,
  output logic             resume_req,
  output logic [15:0]      pause_quanta,
  output logic [15:0]      pause_timer,
  output logic [OCC_W-4:0] hwm_units,
  output logic [OCC_W-4:0] lwm_units
);

  localparam int WM_W     = OCC_W - 3;
  localparam int HI_FLOOR = (FIFO_BYTES * 38) / 100;
  localparam int HI_CAP   = FIFO_BYTES - 8192;
  localparam int LO_CAP   = FIFO_BYTES / 4;
  localparam int QUANTA   = (FIFO_BYTES * 32) / 512;

  int frame, hi_b, lo_b, tmr;
  logic [WM_W-1:0] fill_u;
  logic paused;

  always_comb begin
    frame = int'(cfg_mtu) + 14;
    if (frame > 1536) frame = frame + 4;
    hi_b = FIFO_BYTES - 3 * frame;
    if (hi_b < HI_FLOOR) hi_b = HI_FLOOR;
    if (hi_b > HI_CAP)   hi_b = HI_CAP;
    lo_b = 3 * frame;
    if (lo_b > LO_CAP)   lo_b = LO_CAP;
    tmr = ((hi_b - lo_b) * 4) >>> (cfg_div_sel ? 6 : 3);
  end

  assign fill_u       = fill_bytes[OCC_W-1:3];
  assign pause_quanta = 16'(QUANTA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwm_units   <= '0;
      lwm_units   <= '0;
      pause_timer <= '0;
    end else if (cfg_strobe) begin
      hwm_units   <= cfg_fc_en ? WM_W'(hi_b >>> 3) : '0;
      lwm_units   <= WM_W'(lo_b >>> 3);
      pause_timer <= 16'(tmr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused     <= 1'b0;
      pause_req  <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      pause_req  <= 1'b0;
      resume_req <= 1'b0;
      if (!paused && hwm_units != '0 && fill_u >= hwm_units) begin
        paused    <= 1'b1;
        pause_req <= 1'b1;
      end else if (paused && fill_u <= lwm_units) begin
        paused     <= 1'b0;
        resume_req <= 1'b1;
      end
    end
  end

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pause_req && resume_req));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);
  assert_fc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hwm_units == '0) |=> !pause_req);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_strobe |=> ($stable(hwm_units) && $stable(lwm_units) && $stable(pause_timer)));
  assert_lwm_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lwm_units <= WM_W'(LO_CAP / 8));
  assert_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hwm_units == '0) || (hwm_units > lwm_units));

endmodule

// File: tb/pause_wm_ctrl_bench.sv
module pause_wm_ctrl_bench;
  localparam int FB = 32768;
  localparam int OW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_strobe = 0, cfg_fc_en = 0, cfg_div_sel = 0;
  logic [13:0] cfg_mtu = '0;
  logic [OW-1:0] fill_bytes = '0;
  logic pause_req, resume_req;
  logic [15:0] pause_quanta, pause_timer;
  logic [OW-4:0] hwm_units, lwm_units;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pause_wm_ctrl #(.FIFO_BYTES(FB), .MTU_W(14), .OCC_W(OW)) u_pause_wm_ctrl (
    .clk, .rst_n, .cfg_strobe, .cfg_mtu, .cfg_fc_en, .cfg_div_sel, .fill_bytes,
    .pause_req, .resume_req, .pause_quanta, .pause_timer, .hwm_units, .lwm_units);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(int mtu, bit fc, bit dsel);
    @(negedge clk);
    cfg_mtu = 14'(mtu); cfg_fc_en = fc; cfg_div_sel = dsel; cfg_strobe = 1;
    @(negedge clk);
    cfg_strobe = 0;
  endtask

  task automatic step(int fill, bit ep, bit er, string req);
    fill_bytes = OW'(fill);
    @(negedge clk);
    chk({req, " pause"}, pause_req, ep);
    chk({req, " resume"}, resume_req, er);
  endtask

  task automatic t_reset;
    chk("R10 pause", pause_req, 0);
    chk("R10 resume", resume_req, 0);
    chk("R10 hwm", hwm_units, 0);
    chk("R10 lwm", lwm_units, 0);
    chk("R10 timer", pause_timer, 0);
    chk("R6 quanta", pause_quanta, 2048);
  endtask

  task automatic t_std_mtu;
    load(1500, 1, 0);
    chk("R1 hwm capped", hwm_units, 3072);
    chk("R2 lwm 3x", lwm_units, 567);
    chk("R5 timer div8", pause_timer, 10017);
    load(1500, 1, 1);
    chk("R5 timer div64", pause_timer, 1252);
  endtask

  task automatic t_jumbo;
    load(9000, 1, 0);
    chk("R1 hwm floor", hwm_units, 1556);
    chk("R2 lwm cap", lwm_units, 1024);
    chk("R5 timer jumbo", pause_timer, 2129);
    load(6000, 1, 0);
    chk("R1 hwm mid", hwm_units, 1839);
  endtask

  task automatic t_frame_edge;
    load(1522, 1, 0);
    chk("R3 frame 1536", lwm_units, 576);
    load(1523, 1, 0);
    chk("R3 frame 1541", lwm_units, 577);
  endtask

  task automatic t_hysteresis;
    load(1500, 1, 0);
    step(24568, 0, 0, "R7 below hwm");
    step(24576, 1, 0, "R7 at hwm");
    step(24576, 0, 0, "R7 single pulse");
    step(30000, 0, 0, "R7 no repeat");
    step(10000, 0, 0, "R8 between");
    step(4544, 0, 0, "R8 above lwm");
    step(4543, 0, 1, "R8 at lwm");
    step(4543, 0, 0, "R8 single pulse");
    step(30000, 1, 0, "R7 re-arm");
    step(0, 0, 1, "R8 drain");
  endtask

  task automatic t_fc_off;
    load(1500, 0, 0);
    chk("R4 hwm zero", hwm_units, 0);
    chk("R5 timer fc off", pause_timer, 10017);
    step(32000, 0, 0, "R4 no pause");
    step(32000, 0, 0, "R4 still none");
    step(0, 0, 0, "R4 no resume");
  endtask

  task automatic t_hold;
    load(1500, 1, 0);
    @(negedge clk);
    cfg_mtu = 14'd9000; cfg_fc_en = 0; cfg_div_sel = 1;
    repeat (3) @(negedge clk);
    chk("R9 hwm held", hwm_units, 3072);
    chk("R9 lwm held", lwm_units, 567);
    chk("R9 timer held", pause_timer, 10017);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_std_mtu();
    t_jumbo();
    t_frame_edge();
    t_hysteresis();
    t_fc_off();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule